// File: doc/BRIEF.md
# Prescaled PWM Generator Channel

This block is one channel of pulse-width modulation. A prescaler divides the system clock by 2, 8, 32 or 64 and produces a tick. Each tick advances a 10-bit up-counting timer. On each tick the current count is compared with a period register and with an active duty value. A period hit restarts the timer at zero, drives the output high, copies the buffered duty value into the active comparator and sends a one-cycle interrupt pulse. A duty hit drives the output low.

Software reaches the block through one write port that has a 2-bit address. Address 0 is the period, 1 is the duty buffer, 2 is control and 3 is the timer. The timer value is always visible on a read port. When the channel is disabled, the timer is frozen, the prescaler is held cleared and the output is held low.

Top module: `pwm_chan`

## Requirements
- R1: After reset, tmr_o, pwm_o and irq_o are 0. The period, duty buffer, active duty, control (enable=0, select=00) and prescaler are all 0, so the timer stays at 0 until the block is enabled.
- R2: Control write (wr_addr=2): wr_data[2] is the enable and wr_data[1:0] is the divide select. The select codes are 00 for 2, 01 for 8, 10 for 32 and 11 for 64 system clocks per timer tick.
- R3: On a tick with no period hit, the timer advances by one and wraps from 1023 to 0 with no interrupt.
- R4: On a tick where timer equals period, the timer returns to 0, pwm_o goes high and irq_o pulses for exactly one cycle. Interrupts are therefore (period+1)×divide clocks apart.
- R5: On a tick where timer equals the active duty value and not the period, pwm_o goes low. The high time is (duty+1)×divide clocks.
- R6: A duty write (wr_addr=1) only fills the buffer. The waveform of the running period is unchanged, and the new value applies from the next period hit.
- R7: If duty ≥ period, pwm_o stays high for the whole period.
- R8: If duty is 0, pwm_o is high for exactly one timer count per period.
- R9: While enable is 0, the timer holds its value, pwm_o is 0 and no interrupt occurs.
- R10: A timer write (wr_addr=3) shows on tmr_o after the next clock edge and clears the prescaler, so the following step comes a full divide period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 duty buffer, 2 control, 3 timer |
| wr_data | input | CNT_W | Write data |
| tmr_o | output | CNT_W | Current timer count |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | One-cycle period-match pulse |

## Verification
Most internal faults in this channel show up at the ports within one tick.

| Fault | Effect at the ports |
|---|---|
| Wrong prescaler limit | Stretches every step of tmr_o, visible within one divide period |
| Missed period comparison | Timer runs on past the period; no irq_o |
| Stale or early active duty | Wrong pwm_o high time in the period where the buffer changed |

A behavioural reference model compares tmr_o, pwm_o and irq_o on every clock. Directed measurements of interrupt spacing and high time catch the ratio faults that the model would only report as a count mismatch.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W = 6;
  localparam int CTL_EN_BIT = 2;

  typedef enum logic [1:0] {
    ADDR_PERIOD = 2'd0,
    ADDR_DUTY   = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_TIMER  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    DIV2  = 2'd0,
    DIV8  = 2'd1,
    DIV32 = 2'd2,
    DIV64 = 2'd3
  } div_sel_e;

  // last prescaler count before a tick (divide ratio minus one)
  function automatic logic [PRE_W-1:0] pre_limit(input div_sel_e s);
    case (s)
      DIV2:    pre_limit = PRE_W'(1);
      DIV8:    pre_limit = PRE_W'(7);
      DIV32:   pre_limit = PRE_W'(31);
      default: pre_limit = PRE_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     clr,
  input  div_sel_e sel,
  output logic     tick
);
  logic [PRE_W-1:0] cnt_q;

  // >= keeps the divider sane when the select shrinks mid-count
  assign tick = en && (cnt_q >= pre_limit(sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || clr || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] cnt,
  output logic             period_hit,
  output logic             duty_hit
);
  logic step;

  // a software load wins over a tick in the same cycle
  assign step       = tick && !load;
  assign period_hit = step && (cnt == period);
  assign duty_hit   = step && !period_hit && (cnt == duty_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (period_hit) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             period_hit,
  input  logic             duty_hit,
  input  logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] duty_act,
  output logic             pwm,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_act <= '0;
      pwm      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= period_hit;
      if (period_hit) duty_act <= duty_buf;
      // set has priority over reset; disable forces low
      if (!en)             pwm <= 1'b0;
      else if (period_hit) pwm <= 1'b1;
      else if (duty_hit)   pwm <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] tmr_o,
  output logic             pwm_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] dbuf_q;
  logic [CNT_W-1:0] dact_w;
  div_sel_e         sel_q;
  logic             en_q;
  logic             tick_w;
  logic             tmr_wr_w;
  logic             period_hit_w;
  logic             duty_hit_w;

  assign tmr_wr_w = wr_en && (reg_addr_e'(wr_addr) == ADDR_TIMER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      dbuf_q <= '0;
      sel_q  <= DIV2;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADDR_PERIOD: per_q <= wr_data;
        ADDR_DUTY:   dbuf_q <= wr_data;
        ADDR_CTRL: begin
          sel_q <= div_sel_e'(wr_data[1:0]);
          en_q  <= wr_data[CTL_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  pwm_prescaler pre_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en_q),
    .clr  (tmr_wr_w),
    .sel  (sel_q),
    .tick (tick_w)
  );

  pwm_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .load      (tmr_wr_w),
    .load_val  (wr_data),
    .period    (per_q),
    .duty_act  (dact_w),
    .cnt       (tmr_o),
    .period_hit(period_hit_w),
    .duty_hit  (duty_hit_w)
  );

  pwm_out #(.CNT_W(CNT_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .period_hit(period_hit_w),
    .duty_hit  (duty_hit_w),
    .duty_buf  (dbuf_q),
    .duty_act  (dact_w),
    .pwm       (pwm_o),
    .irq       (irq_o)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] tmr_o,
  input logic             pwm_o,
  input logic             irq_o,
  input logic             en_q,
  input logic             tick,
  input logic             period_hit
);
  logic tw;
  assign tw = wr_en && (wr_addr == 2'd3);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R4
  AST_IRQ_TMR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (tmr_o == '0) && pwm_o); // R4
  AST_IRQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> irq_o); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !period_hit && !tw) |=> tmr_o == $past(tmr_o) + 1'b1); // R3
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !tw) |=> $stable(tmr_o)); // R9
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !pwm_o && !irq_o); // R9
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tw |=> tmr_o == $past(wr_data)); // R10
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .tmr_o     (tmr_o),
  .pwm_o     (pwm_o),
  .irq_o     (irq_o),
  .en_q      (en_q),
  .tick      (tick_w),
  .period_hit(period_hit_w)
);

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = 10'd0;
  logic [9:0] tmr_o;
  logic       pwm_o, irq_o;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 1'b0;

  // reference model state
  int m_tmr, m_per, m_dbuf, m_dact, m_sel, m_pre;
  bit m_en, m_pwm, m_irq;

  always #5 clk = ~clk;

  pwm_chan dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_o(tmr_o), .pwm_o(pwm_o), .irq_o(irq_o));

  function automatic int ratio(int s);
    case (s)
      0: return 2;
      1: return 8;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    bit tk, ph, dh, ld;
    if (!rst_n) begin
      m_tmr = 0; m_per = 0; m_dbuf = 0; m_dact = 0; m_sel = 0; m_pre = 0;
      m_en = 0; m_pwm = 0; m_irq = 0;
    end else begin
      tk = m_en && (m_pre + 1 >= ratio(m_sel));
      ld = wr_en && wr_addr == 2'd3;
      ph = 0; dh = 0;
      if (ld) m_tmr = int'(wr_data);
      else if (tk) begin
        if (m_tmr == m_per) begin ph = 1; m_tmr = 0; end
        else begin dh = (m_tmr == m_dact); m_tmr = (m_tmr + 1) % 1024; end
      end
      m_irq = ph;
      if (ph) m_dact = m_dbuf;
      if (!m_en) m_pwm = 0; else if (ph) m_pwm = 1; else if (dh) m_pwm = 0;
      if (!m_en || ld || tk) m_pre = 0; else m_pre = m_pre + 1;
      if (wr_en) case (wr_addr)
        2'd0: m_per = int'(wr_data);
        2'd1: m_dbuf = int'(wr_data);
        2'd2: begin m_sel = int'(wr_data[1:0]); m_en = wr_data[2]; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      total++;
      if (int'(tmr_o) != m_tmr || pwm_o != m_pwm || irq_o != m_irq) begin
        bad++;
        $display("FAIL model R3 R4 R5 R6 R9 R10: act tmr=%0d pwm=%0d irq=%0d exp tmr=%0d pwm=%0d irq=%0d",
                 tmr_o, pwm_o, irq_o, m_tmr, m_pwm, m_irq);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    int g = 0;
    @(negedge clk);
    while (!irq_o && g < 5000) begin @(negedge clk); g++; end
  endtask

  // starts on a negedge where irq_o is high, ends on the next such negedge
  task automatic measure(int exp_n, int exp_h, int mid_duty, string req);
    int n = 0, h = 0;
    do begin
      if (pwm_o) h++;
      n++;
      if (mid_duty >= 0 && n == 3) begin wr_en = 1; wr_addr = 2'd1; wr_data = 10'(mid_duty); end
      if (n == 4) wr_en = 0;
      @(negedge clk);
    end while (!irq_o && n < 5000);
    check(n == exp_n, {req, " period clocks"}, n, exp_n);
    check(h == exp_h, {req, " high clocks"}, h, exp_h);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t, hi, irqs, g;
    bit saw_top;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    check(tmr_o == 0 && pwm_o == 0 && irq_o == 0, "R1 reset outputs", int'(tmr_o), 0);
    repeat (20) @(negedge clk);
    check(tmr_o == 0, "R1 idle after reset", int'(tmr_o), 0);

    // R2 R4 R5: /2, period 9, duty 3
    wr(0, 9); wr(1, 3); wr(2, 4);
    wait_irq(); measure(20, 8, -1, "R2 R4 R5 div2");
    // R6: duty changed mid period, old value still used
    measure(20, 8, 6, "R6 buffered duty");
    measure(20, 14, -1, "R6 new duty applied");
    wr(1, 3); wr(2, 4 | 1);
    wait_irq(); measure(80, 32, -1, "R2 div8");
    wr(0, 4); wr(1, 1); wr(2, 4 | 2);
    wait_irq(); measure(160, 64, -1, "R2 div32");
    wr(2, 4 | 3);
    wait_irq(); measure(320, 128, -1, "R2 div64");
    // R8 duty zero
    wr(0, 9); wr(1, 0); wr(2, 4);
    wait_irq(); measure(20, 2, -1, "R8 duty zero");
    // R7 duty above and equal to period
    wr(1, 12);
    wait_irq(); measure(20, 20, -1, "R7 duty>period");
    wr(1, 9);
    wait_irq(); measure(20, 20, -1, "R7 duty=period");

    // R9 disable
    wr(2, 0);
    @(negedge clk);
    t = int'(tmr_o); hi = 0; irqs = 0;
    repeat (40) begin
      @(negedge clk);
      if (pwm_o) hi++;
      if (irq_o) irqs++;
    end
    check(int'(tmr_o) == t, "R9 timer held", int'(tmr_o), t);
    check(hi == 0, "R9 output low", hi, 0);
    check(irqs == 0, "R9 no interrupt", irqs, 0);

    // R10 timer write
    wr(3, 5);
    check(tmr_o == 5, "R10 timer write", int'(tmr_o), 5);

    // R3 wrap through 1023 without interrupt
    wr(0, 3); wr(1, 1); wr(3, 1020); wr(2, 4);
    saw_top = 0; g = 0;
    while (tmr_o != 0 && g < 100) begin
      if (tmr_o == 10'd1023) saw_top = 1;
      @(negedge clk); g++;
    end
    check(saw_top, "R3 reached 1023", int'(saw_top), 1);
    check(tmr_o == 0 && irq_o == 0, "R3 wrap no irq", int'(irq_o), 0);

    // R10 prescaler cleared by timer write (div8)
    wr(0, 1000); wr(2, 4 | 1);
    repeat (5) @(negedge clk);
    wr(3, 100);
    g = 0;
    while (tmr_o == 10'd100 && g < 100) begin @(negedge clk); g++; end
    check(g == 8, "R10 prescaler cleared", g, 8);
    check(tmr_o == 101, "R3 step after load", int'(tmr_o), 101);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule